// File: doc/BRIEF.md
# Minutes, Seconds and Hundredths Clock

This block keeps a running time of day limited to minutes, seconds and hundredths of a second. Each field is held as a pair of BCD digits, and each of the six digits drives its own active-low seven-segment output. No display scanning is involved. A prescaler divides the system clock down to a 100 Hz count enable. The divide ratio is a parameter, so the same block can be fitted to any system clock.

Two push-button inputs control the clock. Both are active low and asynchronous.

- **Preset key:** while it is down, the minutes field follows an 8-bit switch bus that carries two BCD digits. Illegal digits are clamped.
- **Hold key:** while it is down, counting stops. The prescaler is frozen together with the digits, so the partial hundredth already accumulated is kept. When the key is released, counting continues exactly where it stopped.

A synchronous active-high reset returns the display to 00:00.00.

Top module: `rtc_centi`

## Requirements
- R1: While `rst` is high at a rising edge, all six digits and the prescaler are cleared, so every segment output shows the digit 0 (7'h40).
- R2: While both keys are released, the hundredths value advances by exactly one every `TICK_DIV` clock cycles. The first advance comes `TICK_DIV` edges after reset is released.
- R3: Hundredths count 00 to 99. The step after 99 gives 00 and advances the seconds by one.
- R4: Seconds count 00 to 59. The step after 59 gives 00 and advances the minutes by one.
- R5: Minutes count 00 to 59. The step after 59 gives 00.
- R6: `seg5`/`seg4` show the minute tens/units, `seg3`/`seg2` the second tens/units, and `seg1`/`seg0` the hundredth tens/units.
- R7: Each segment output is active low, with bit 0 = segment a through bit 6 = segment g. Digits 0..9 encode as 7'h40, 7'h79, 7'h24, 7'h30, 7'h19, 7'h12, 7'h02, 7'h78, 7'h00 and 7'h10.
- R8: Each key passes through a two-flop synchroniser. A key change driven between edges first acts at the third rising edge after it.
- R9: While the synchronised preset key is low, minutes load from `min_sw`. The tens digit is `min_sw[7:4]`, clamped to 5 when above 5. The units digit is `min_sw[3:0]`, clamped to 9 when above 9.
- R10: While preset is active, the seconds, the hundredths and the prescaler do not change. Preset acts even while hold is active.
- R11: While the synchronised hold key is low, all digits and the prescaler stay unchanged. After release, counting resumes from the retained prescaler phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| preset_n | input | 1 | Minute preset key, active low, asynchronous |
| hold_n | input | 1 | Hold key, active low, asynchronous |
| min_sw | input | 8 | Minute preset value, BCD tens in [7:4], units in [3:0] |
| seg5 | output | 7 | Minute tens segments, active low, bit 0 = a |
| seg4 | output | 7 | Minute units segments |
| seg3 | output | 7 | Second tens segments |
| seg2 | output | 7 | Second units segments |
| seg1 | output | 7 | Hundredth tens segments |
| seg0 | output | 7 | Hundredth units segments |

## Verification
The bench runs past the first hundredths wrap and onward into the next minute. This catches a counter that wraps at 9 or 10 instead of 99 or 59, and a carry that fires one step early or late. It then presets 59 minutes and runs through the minute wrap, which a design with a bad limit would show as 60 or 00 at the wrong moment.

All 256 switch values are swept through the preset. An unclamped design would show hex garbage or a blank digit instead of 5 or 9.

Hold is applied across a prescaler boundary, and a preset is applied during a hold. A design that resets its prescaler on hold, drops the synchroniser delay, or lets a preset touch seconds would drift from the cycle-accurate bench model.

// File: rtl/rtc_centi.sv
module rtc_centi #(
  parameter int TICK_DIV = 500000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       preset_n,
  input  logic       hold_n,
  input  logic [7:0] min_sw,
  output logic [6:0] seg5,
  output logic [6:0] seg4,
  output logic [6:0] seg3,
  output logic [6:0] seg2,
  output logic [6:0] seg1,
  output logic [6:0] seg0
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(TICK_DIV - 1);

  logic [1:0] pre_sync, hold_sync;
  logic [PW-1:0] pre_cnt;
  logic [3:0] m1, m0, s1, s0, c1, c0;

  wire preset_act = ~pre_sync[1];
  wire hold_act   = ~hold_sync[1];
  wire run        = ~preset_act & ~hold_act;
  wire tick       = run & (pre_cnt == PRE_LAST);

  wire c0_wrap = tick    & (c0 == 4'd9);
  wire c1_wrap = c0_wrap & (c1 == 4'd9);
  wire s0_wrap = c1_wrap & (s0 == 4'd9);
  wire s1_wrap = s0_wrap & (s1 == 4'd5);
  wire m0_wrap = s1_wrap & (m0 == 4'd9);

  wire [3:0] sw_tens  = (min_sw[7:4] > 4'd5) ? 4'd5 : min_sw[7:4];
  wire [3:0] sw_units = (min_sw[3:0] > 4'd9) ? 4'd9 : min_sw[3:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_sync  <= 2'b11;
      hold_sync <= 2'b11;
    end else begin
      pre_sync  <= {pre_sync[0], preset_n};
      hold_sync <= {hold_sync[0], hold_n};
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       pre_cnt <= '0;
    else if (tick) pre_cnt <= '0;
    else if (run)  pre_cnt <= pre_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      {m1, m0, s1, s0, c1, c0} <= '0;
    end else begin
      if (tick)    c0 <= (c0 == 4'd9) ? 4'd0 : c0 + 4'd1;
      if (c0_wrap) c1 <= (c1 == 4'd9) ? 4'd0 : c1 + 4'd1;
      if (c1_wrap) s0 <= (s0 == 4'd9) ? 4'd0 : s0 + 4'd1;
      if (s0_wrap) s1 <= (s1 == 4'd5) ? 4'd0 : s1 + 4'd1;
      if (preset_act) begin
        m1 <= sw_tens;
        m0 <= sw_units;
      end else begin
        if (s1_wrap) m0 <= (m0 == 4'd9) ? 4'd0 : m0 + 4'd1;
        if (m0_wrap) m1 <= (m1 == 4'd5) ? 4'd0 : m1 + 4'd1;
      end
    end
  end

  function automatic logic [6:0] seg7(input logic [3:0] d);
    case (d)
      4'd0: seg7 = 7'h40;
      4'd1: seg7 = 7'h79;
      4'd2: seg7 = 7'h24;
      4'd3: seg7 = 7'h30;
      4'd4: seg7 = 7'h19;
      4'd5: seg7 = 7'h12;
      4'd6: seg7 = 7'h02;
      4'd7: seg7 = 7'h78;
      4'd8: seg7 = 7'h00;
      4'd9: seg7 = 7'h10;
      default: seg7 = 7'h7F;
    endcase
  endfunction

  assign seg5 = seg7(m1);
  assign seg4 = seg7(m0);
  assign seg3 = seg7(s1);
  assign seg2 = seg7(s0);
  assign seg1 = seg7(c1);
  assign seg0 = seg7(c0);

  wire [23:0] bcd_now = {m1, m0, s1, s0, c1, c0};
endmodule

module rtc_centi_chk #(
  parameter int TICK_DIV = 500000,
  parameter int PW = 19
) (
  input logic          clk,
  input logic          rst,
  input logic          preset_act,
  input logic          hold_act,
  input logic [PW-1:0] pre_cnt,
  input logic [23:0]   bcd_now
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (bcd_now == 24'd0 && pre_cnt == '0));
  // R2
  pre_bound_chk: assert property (@(posedge clk) disable iff (rst)
    pre_cnt <= PW'(TICK_DIV - 1));
  // R3
  hund_range_chk: assert property (@(posedge clk) disable iff (rst)
    bcd_now[7:4] <= 4'd9 && bcd_now[3:0] <= 4'd9);
  // R4
  sec_range_chk: assert property (@(posedge clk) disable iff (rst)
    bcd_now[15:12] <= 4'd5 && bcd_now[11:8] <= 4'd9);
  // R5
  min_range_chk: assert property (@(posedge clk) disable iff (rst)
    bcd_now[23:20] <= 4'd5 && bcd_now[19:16] <= 4'd9);
  // R10
  preset_keep_chk: assert property (@(posedge clk) disable iff (rst)
    preset_act |=> ($stable(bcd_now[15:0]) && $stable(pre_cnt)));
  // R11
  hold_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (hold_act && !preset_act) |=> ($stable(bcd_now) && $stable(pre_cnt)));
endmodule

bind rtc_centi rtc_centi_chk #(.TICK_DIV(TICK_DIV), .PW(PW)) u_chk (
  .clk(clk), .rst(rst), .preset_act(preset_act), .hold_act(hold_act),
  .pre_cnt(pre_cnt), .bcd_now(bcd_now)
);

// File: tb/rtc_centi_tb.sv
`timescale 1ns/1ps
module rtc_centi_tb;
  localparam int DIV = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic preset_n = 1'b1;
  logic hold_n = 1'b1;
  logic [7:0] min_sw = 8'h00;
  logic [6:0] seg5, seg4, seg3, seg2, seg1, seg0;

  int errors = 0;
  int checks = 0;
  int m = 0, s = 0, h = 0, pre = 0;
  bit mp1 = 1, mp2 = 1, hp1 = 1, hp2 = 1;

  always #2.5 clk = ~clk;

  rtc_centi #(.TICK_DIV(DIV)) u_dut (
    .clk(clk), .rst(rst), .preset_n(preset_n), .hold_n(hold_n), .min_sw(min_sw),
    .seg5(seg5), .seg4(seg4), .seg3(seg3), .seg2(seg2), .seg1(seg1), .seg0(seg0)
  );

  function automatic logic [6:0] pat(input int d);
    case (d)
      0: pat = 7'h40; 1: pat = 7'h79; 2: pat = 7'h24; 3: pat = 7'h30; 4: pat = 7'h19;
      5: pat = 7'h12; 6: pat = 7'h02; 7: pat = 7'h78; 8: pat = 7'h00; 9: pat = 7'h10;
      default: pat = 7'h7F;
    endcase
  endfunction

  function automatic int clampv(input logic [7:0] v);
    int t = (v[7:4] > 5) ? 5 : int'(v[7:4]);
    int u = (v[3:0] > 9) ? 9 : int'(v[3:0]);
    return t * 10 + u;
  endfunction

  task automatic check(input string tag, input logic [41:0] got, input logic [41:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic cyc(input string tag);
    @(posedge clk);
    if (rst) begin
      m = 0; s = 0; h = 0; pre = 0; mp1 = 1; mp2 = 1; hp1 = 1; hp2 = 1;
    end else begin
      if (!mp2) m = clampv(min_sw);
      else if (hp2) begin
        if (pre == DIV - 1) begin
          pre = 0; h++;
          if (h == 100) begin
            h = 0; s++;
            if (s == 60) begin s = 0; m = (m + 1) % 60; end
          end
        end else pre++;
      end
      mp2 = mp1; mp1 = preset_n; hp2 = hp1; hp1 = hold_n;
    end
    @(negedge clk);
    check(tag, {seg5, seg4, seg3, seg2, seg1, seg0},
          {pat(m / 10), pat(m % 10), pat(s / 10), pat(s % 10), pat(h / 10), pat(h % 10)});
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(tag);
  endtask

  initial begin
    #(5.0 * 100000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    run(3, "R1");
    rst = 1'b0;
    run(100 * DIV, "R2");
    run(5900 * DIV, "R3");
    run(200 * DIV, "R4");
    for (int v = 0; v < 256; v++) begin
      preset_n = 1'b0; min_sw = 8'(v);
      run(4, "R9");
      preset_n = 1'b1;
      run(3, "R9");
    end
    preset_n = 1'b0; min_sw = 8'h37;
    run(4, "R9");
    preset_n = 1'b1;
    run(3, "R6");
    checks++;
    if (seg5 !== 7'h30 || seg4 !== 7'h78) begin
      errors++;
      $display("FAIL R6/R7 minutes got %h %h expected 30 78", seg5, seg4);
    end
    preset_n = 1'b0; min_sw = 8'h59;
    run(4, "R9");
    preset_n = 1'b1;
    run(6000 * DIV, "R5");
    run(1, "R8");
    hold_n = 1'b0;
    run(3, "R8");
    run(41, "R11");
    hold_n = 1'b1;
    run(7, "R11");
    hold_n = 1'b0;
    run(5, "R10");
    preset_n = 1'b0; min_sw = 8'h12;
    run(5, "R10");
    preset_n = 1'b1;
    run(5, "R10");
    hold_n = 1'b1;
    run(10, "R10");
    checks++;
    if (seg5 !== 7'h79 || seg4 !== 7'h24) begin
      errors++;
      $display("FAIL R10 minutes got %h %h expected 79 24", seg5, seg4);
    end
    rst = 1'b1;
    run(1, "R1");
    rst = 1'b0;
    run(10, "R2");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule